// File: doc/BRIEF.md
# Serial Transmit Sequencer for Data, Preamble and Break

This block is the transmit engine of an asynchronous serial port. It sends three kinds of characters on one output line. Data frames come in through a valid/ready handshake. An idle preamble holds the line high for one frame length. A break holds the line low for longer than one frame. A single-cycle bit-time strobe from an external baud generator sets the pace. The engine changes the line only on that strobe.

The engine has three states: Idle, Ready and Busy. Turning the enable on moves it out of Idle, sets an internal commit indication and arms a preamble. A held send-break control repeats break characters with no gap between them. Once that control is released, or the enable is dropped, the break in progress runs to its end and one stop bit follows it. Dropping the enable never cuts short a character in progress: the engine finishes it, sends its stop bit and then enters Idle. A sticky transfer-complete flag reports the end of the work, and software clears it by writing one.

Top module: `uart_brk_seq`

## Requirements
- R1: A data frame is one low start bit, then the DATA_W data bits least significant bit first, then one high stop bit. Each bit lasts one strobe period. A word is taken when `din_valid` and `din_ready` are both high on a clock edge. `din_ready` is high only in Ready, with the engine enabled, on a strobe cycle, and with no break or preamble pending.
- R2: `txd` is high in Idle and in Ready. `txd` changes only on a clock edge where `bit_tick` is high.
- R3: When `tx_en` is high in Idle, the engine enters Ready on the next edge, sets `commit` and arms a preamble. A `pre_req` pulse while enabled and out of Idle also arms a preamble.
- R4: On a strobe in Ready, a held `send_brk` starts a break. Otherwise an armed preamble starts and is disarmed. Otherwise a valid data word starts.
- R5: A preamble holds `txd` high for DATA_W+2 bit times.
- R6: A break holds `txd` low for BRK_BITS bit times. While `send_brk` stays high and the engine stays enabled, the next break follows directly with the line still low.
- R7: If `send_brk` is low or `tx_en` is low when a break ends, the engine sends one high stop bit and only then leaves Busy.
- R8: When a data frame, a preamble or a closing stop bit ends while the engine is enabled, it returns to Ready. It sets `tc` only if `din_valid`, `send_brk` and the armed preamble are all low.
- R9: When such a character ends with `tx_en` low, the engine enters Idle, always sets `tc` and clears `commit`.
- R10: `tc` stays set until a `tc_clr` pulse. If a clear and a set fall on the same edge, `tc` ends up set.
- R11: If `tx_en` is low in Ready, the engine enters Idle on the next edge. It clears `commit` and disarms the preamble, and `tc` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmitter enable |
| send_brk | input | 1 | Send-break control |
| pre_req | input | 1 | Pulse that arms a preamble |
| din | input | DATA_W | Data word to send |
| din_valid | input | 1 | Data word is valid |
| din_ready | output | 1 | Data word taken on this edge |
| bit_tick | input | 1 | One-cycle bit-time strobe |
| tc_clr | input | 1 | Write-one clear of transfer-complete |
| txd | output | 1 | Serial line |
| tc | output | 1 | Sticky transfer-complete flag |
| commit | output | 1 | Internal commit indication |

## Verification
A wrong state or pending bit shows up on `din_ready` or `txd` at the first strobe after the fault. The strobe can start the wrong character, or it can stall or lengthen one. A miscounted bit shows up at the end of that character, where the line level or the start of the stop bit lands one strobe early or late. Errors in completion handling show up on `tc` and `commit` on the clock edge after the final strobe. That is why the bench compares every output with a behavioural model on every clock.

// File: rtl/uart_brk_seq.sv
module uart_brk_seq #(
  parameter int DATA_W   = 8,
  parameter int BRK_BITS = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              send_brk,
  input  logic              pre_req,
  input  logic [DATA_W-1:0] din,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic              bit_tick,
  input  logic              tc_clr,
  output logic              txd,
  output logic              tc,
  output logic              commit
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int CW = $clog2(BRK_BITS);

  typedef enum logic [1:0] {S_IDLE, S_READY, S_BUSY} st_t;
  typedef enum logic [1:0] {K_DATA, K_PRE, K_BRK, K_STOP} kd_t;

  st_t             state;
  kd_t             kind;
  logic            pre_pend;
  logic [DATA_W:0] sh;
  logic [CW-1:0]   cnt;

  wire go        = (state == S_READY) && tx_en && bit_tick;
  assign din_ready = go && !send_brk && !pre_pend;
  wire last      = (state == S_BUSY) && bit_tick && (cnt == '0);
  wire fin       = last && (kind != K_BRK);
  wire pending   = din_valid | pre_pend | send_brk;
  wire tc_set    = fin && (!tx_en || !pending);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      kind     <= K_DATA;
      txd      <= 1'b1;
      tc       <= 1'b0;
      commit   <= 1'b0;
      pre_pend <= 1'b0;
      sh       <= '1;
      cnt      <= '0;
    end else begin
      tc <= tc_set | (tc & ~tc_clr);
      case (state)
        S_IDLE:
          if (tx_en) begin
            state    <= S_READY;
            commit   <= 1'b1;
            pre_pend <= 1'b1;
          end
        S_READY:
          if (!tx_en) begin
            state    <= S_IDLE;
            commit   <= 1'b0;
            pre_pend <= 1'b0;
          end else begin
            if (pre_req) pre_pend <= 1'b1;
            if (bit_tick) begin
              if (send_brk) begin
                state <= S_BUSY;
                kind  <= K_BRK;
                txd   <= 1'b0;
                cnt   <= CW'(BRK_BITS - 1);
              end else if (pre_pend) begin
                state    <= S_BUSY;
                kind     <= K_PRE;
                txd      <= 1'b1;
                cnt      <= CW'(FRAME_BITS - 1);
                pre_pend <= pre_req;
              end else if (din_valid) begin
                state <= S_BUSY;
                kind  <= K_DATA;
                txd   <= 1'b0;
                sh    <= {1'b1, din};
                cnt   <= CW'(FRAME_BITS - 1);
              end
            end
          end
        default: begin
          if (pre_req && tx_en) pre_pend <= 1'b1;
          if (bit_tick) begin
            if (cnt != '0) begin
              cnt <= cnt - 1'b1;
              if (kind == K_DATA) begin
                txd <= sh[0];
                sh  <= {1'b1, sh[DATA_W:1]};
              end
            end else if (kind == K_BRK) begin
              if (send_brk && tx_en) begin
                cnt <= CW'(BRK_BITS - 1);
              end else begin
                kind <= K_STOP;
                txd  <= 1'b1;
              end
            end else begin
              txd <= 1'b1;
              if (tx_en) begin
                state <= S_READY;
              end else begin
                state    <= S_IDLE;
                commit   <= 1'b0;
                pre_pend <= 1'b0;
              end
            end
          end
        end
      endcase
    end
  end

  AST_LINE_HIGH_OUT_OF_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_BUSY) |-> txd); // R2
  AST_LINE_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd)); // R2
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (din_ready && din_valid) |=> (!txd && state == S_BUSY)); // R1
  AST_STOP_AFTER_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (last && kind == K_BRK && !(send_brk && tx_en)) |=> (txd && state == S_BUSY)); // R7
  AST_ENABLE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && tx_en) |=> (commit && pre_pend && state == S_READY)); // R3
  AST_HALT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !tx_en) |=> (state == S_IDLE && !commit && tc)); // R9
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_set && tc_clr) |=> tc); // R10
  AST_IDLE_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !commit); // R11
endmodule

// File: tb/uart_brk_seq_test.sv
module uart_brk_seq_test;
  localparam int DW = 8;
  localparam int BB = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 0, send_brk = 0, pre_req = 0, din_valid = 0, bit_tick = 0, tc_clr = 0;
  logic [DW-1:0] din = '0;
  logic din_ready, txd, tc, commit;

  uart_brk_seq #(.DATA_W(DW), .BRK_BITS(BB)) uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .send_brk(send_brk), .pre_req(pre_req),
    .din(din), .din_valid(din_valid), .din_ready(din_ready), .bit_tick(bit_tick),
    .tc_clr(tc_clr), .txd(txd), .tc(tc), .commit(commit));

  always #2 clk = ~clk;

  int vectors = 0, errors = 0, cyc = 0, tphase = 0, feed = 0;
  bit random_ticks = 0;
  string req = "R2";

  // behavioural reference: 0 idle, 1 ready, 2 busy; kind 0 data, 1 preamble, 2 break, 3 stop
  int m_st = 0, m_kind = 0;
  bit m_line = 1, m_tc = 0, m_com = 0, m_pend = 0;
  bit q[$];

  function automatic bit m_ready();
    return m_st == 1 && tx_en && bit_tick && !send_brk && !m_pend;
  endfunction

  always @(posedge clk) begin
    bit setf, pend_old;
    setf = 0;
    pend_old = m_pend;
    if (!rst_n) begin
      m_st = 0; m_kind = 0; m_line = 1; m_tc = 0; m_com = 0; m_pend = 0; q.delete();
    end else begin
      if (m_st == 0) begin
        if (tx_en) begin m_st = 1; m_com = 1; m_pend = 1; end
      end else if (m_st == 1) begin
        if (!tx_en) begin m_st = 0; m_com = 0; m_pend = 0; end
        else begin
          if (pre_req) m_pend = 1;
          if (bit_tick) begin
            if (send_brk) begin
              m_st = 2; m_kind = 2; m_line = 0;
              q.delete(); repeat (BB - 1) q.push_back(1'b0);
            end else if (pend_old) begin
              m_st = 2; m_kind = 1; m_line = 1; m_pend = pre_req;
              q.delete(); repeat (DW + 1) q.push_back(1'b1);
            end else if (din_valid) begin
              m_st = 2; m_kind = 0; m_line = 0;
              q.delete();
              for (int i = 0; i < DW; i++) q.push_back(din[i]);
              q.push_back(1'b1);
            end
          end
        end
      end else begin
        if (pre_req && tx_en) m_pend = 1;
        if (bit_tick) begin
          if (q.size() > 0) m_line = q.pop_front();
          else if (m_kind == 2) begin
            if (send_brk && tx_en) repeat (BB - 1) q.push_back(1'b0);
            else begin m_kind = 3; m_line = 1; end
          end else begin
            m_line = 1;
            if (tx_en) begin
              m_st = 1;
              setf = !(din_valid || pend_old || send_brk);
            end else begin
              m_st = 0; m_com = 0; m_pend = 0; setf = 1;
            end
          end
        end
      end
      m_tc = setf ? 1'b1 : (tc_clr ? 1'b0 : m_tc);
    end
  end

  task automatic cmp(string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cyc++;
      cmp("txd", txd, m_line);
      cmp("tc", tc, m_tc);
      cmp("commit", commit, m_com);
      if (feed > 0 && din_valid === 1'b0) din_valid = 1;
      tphase = (tphase + 1) % 4;
      bit_tick = random_ticks ? ($urandom_range(0, 2) == 0) : (tphase == 0);
      #1;
      cmp("din_ready", din_ready, m_ready());
      if (din_valid && din_ready && feed > 0) begin
        @(negedge clk);
        cyc++;
        cmp("txd", txd, m_line);
        cmp("tc", tc, m_tc);
        cmp("commit", commit, m_com);
        feed--;
        din = DW'($urandom);
        if (feed == 0) din_valid = 0;
        tphase = (tphase + 1) % 4;
        bit_tick = random_ticks ? ($urandom_range(0, 2) == 0) : (tphase == 0);
        #1;
        cmp("din_ready", din_ready, m_ready());
      end
    end
  endtask

  task automatic pulse_pre();
    pre_req = 1; step(1); pre_req = 0;
  endtask

  task automatic pulse_clr();
    tc_clr = 1; step(1); tc_clr = 0;
  endtask

  initial begin
    req = "R2";
    step(4);
    rst_n = 1;
    step(4);
    // R3 enable from idle, then preamble (R5)
    req = "R3"; tx_en = 1; step(2);
    req = "R5"; step(60);
    // R1 data frames
    req = "R1"; din = 8'hA5; feed = 4; step(220);
    req = "R10"; pulse_clr(); step(8);
    // R4 priority among all three requests
    req = "R4"; din = 8'h3C; feed = 1; pulse_pre(); send_brk = 1; step(40);
    req = "R6"; step(160);
    req = "R7"; send_brk = 0; step(160);
    req = "R8"; pulse_clr(); din = 8'h81; feed = 2; step(120);
    // R9 disable during break and during preamble
    req = "R9"; send_brk = 1; step(20); tx_en = 0; step(30); send_brk = 0; step(80);
    pulse_clr(); tx_en = 1; step(12); tx_en = 0; step(80);
    // R11 disable while ready
    req = "R11"; pulse_clr(); tx_en = 1; step(80); tx_en = 0; step(10);
    // mixed random traffic
    req = "R8"; random_ticks = 1;
    for (int r = 0; r < 3000; r++) begin
      tx_en     = ($urandom_range(0, 19) != 0);
      send_brk  = ($urandom_range(0, 9) == 0);
      pre_req   = ($urandom_range(0, 14) == 0);
      tc_clr    = ($urandom_range(0, 5) == 0);
      din_valid = ($urandom_range(0, 2) != 0);
      din       = DW'($urandom);
      step(1 + $urandom_range(0, 6));
    end
    pre_req = 0; tc_clr = 0; send_brk = 0;
    req = "R2"; rst_n = 0; step(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #600000;
    errors++;
    $display("FAIL R2 watchdog actual=%0d cycles expected<150000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule